// File: doc/BRIEF.md
# DAC update trigger selector

This block decides, on every clock cycle, whether the output register of a digital-to-analog converter should take its next sample. It sees four timer overflow pulses, eight asynchronous external trigger lines and a strobe that marks a write to the data register. A 3-bit mode field chooses among these sources. A 3-bit line select chooses which external line feeds the edge detector. An inhibit bit and an enable bit gate the result.

The output is a registered pulse, one clock wide for each qualifying event. External lines are brought into the clock domain by a two-flop synchronizer before their edges are detected. Timer overflows are taken as synchronous single-cycle pulses and pass straight through. The block has no data stream, so all of its pins are plain control or status lines with no handshake.

Top module: `dac_trig_sel`

## Requirements
- R1: While reset is held and right after it is released, `upd_pulse` is low.
- R2: For mode values 0 to 3, a high `tmr_ovf[k]`, where k equals the mode value, gives `upd_pulse` high in the following cycle. The other timer bits have no effect.
- R3: In mode 4, a low-to-high change on `ext_trig[ext_sel]` gives `upd_pulse` high in the third cycle after the change, counting the two synchronizer flops and the output flop. A high-to-low change gives nothing.
- R4: In mode 5, only a high-to-low change on the selected line gives the pulse, with the same three-cycle latency.
- R5: In mode 6, both directions of change on the selected line give a pulse.
- R6: In mode 7, `data_wr` high gives `upd_pulse` high in the next cycle. In modes 0 to 6, `data_wr` has no effect. In modes 4 to 7, timer pulses have no effect.
- R7: `ext_sel` (0 to 7) picks the external line. Changes on any other line have no effect.
- R8: With `inhibit` high, no source causes a pulse in modes 0 to 6. In mode 7, `data_wr` still causes a pulse.
- R9: With `enable` low, `upd_pulse` stays low in every mode.
- R10: A cycle in which `ext_sel` or `mode` differs from its value in the previous cycle produces no edge event. The edge history is reloaded from the newly selected line in that cycle.
- R11: An isolated qualifying event gives exactly one high cycle on `upd_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_ovf | input | 4 | Timer overflow pulses, synchronous, one cycle each |
| ext_trig | input | 8 | Asynchronous external trigger lines |
| mode | input | 3 | Update source: 0-3 timer k, 4 rise, 5 fall, 6 any edge, 7 on demand |
| ext_sel | input | 3 | Index of the external line used by modes 4-6 |
| inhibit | input | 1 | Blocks every source except on-demand writes |
| enable | input | 1 | Block enable; low suppresses all pulses |
| data_wr | input | 1 | Data register write strobe |
| upd_pulse | output | 1 | Registered single-cycle update request |

## Verification
Two functions can land in the same cycle: a change of `ext_sel`, and the arrival of a synchronized edge on the newly selected line. The bench raises line 1 while line 0 is selected. It then switches the select in exactly the cycle when the synchronized line 1 goes high, so the reload and the edge coincide. The pulse count over the following cycles must be zero. The bench also checks that an edge on the new line that arrives only after settling still produces one pulse.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_TMR0   = 3'd0,
    MD_TMR1   = 3'd1,
    MD_TMR2   = 3'd2,
    MD_TMR3   = 3'd3,
    MD_RISE   = 3'd4,
    MD_FALL   = 3'd5,
    MD_ANY    = 3'd6,
    MD_DEMAND = 3'd7
  } upd_mode_e;
endpackage

// File: rtl/dtrig_sync.sv
module dtrig_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/dtrig_edge.sv
module dtrig_edge
  import dac_trig_pkg::*;
#(
  parameter int unsigned N_EXT = 8,
  localparam int unsigned SEL_W = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  synced_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              rise_o,
  output logic              fall_o
);
  logic              cur;
  logic              hist_q;
  logic [SEL_W-1:0]  sel_q;
  logic [MODE_W-1:0] mode_q;
  logic              cfg_chg;

  assign cur     = synced_i[sel_i];
  assign cfg_chg = (sel_i != sel_q) || (mode_i != mode_q);

  // History always tracks the currently selected line, so a select change
  // reloads it in the same cycle; the edge of that cycle is discarded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      sel_q  <= '0;
      mode_q <= '0;
    end else begin
      hist_q <= cur;
      sel_q  <= sel_i;
      mode_q <= mode_i;
    end
  end

  assign rise_o = !cfg_chg &&  cur && !hist_q;
  assign fall_o = !cfg_chg && !cur &&  hist_q;

  assert_no_edge_on_reselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_i) |-> !(rise_o || fall_o));

  assert_edges_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
endmodule

// File: rtl/dtrig_qual.sv
module dtrig_qual
  import dac_trig_pkg::*;
#(
  parameter int unsigned N_TMR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TMR-1:0]  tmr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              inhibit_i,
  input  logic              enable_i,
  input  logic              data_wr_i,
  output logic              upd_o
);
  upd_mode_e md;
  logic      src_hit;
  logic      demand_hit;
  logic      fire;

  assign md = upd_mode_e'(mode_i);

  always_comb begin
    src_hit = 1'b0;
    unique case (md)
      MD_RISE:   src_hit = rise_i;
      MD_FALL:   src_hit = fall_i;
      MD_ANY:    src_hit = rise_i | fall_i;
      MD_DEMAND: src_hit = 1'b0;
      default: begin
        for (int k = 0; k < N_TMR; k++)
          if (mode_i == MODE_W'(k)) src_hit = tmr_i[k];
      end
    endcase
  end

  assign demand_hit = (md == MD_DEMAND) && data_wr_i;
  assign fire       = enable_i && (demand_hit || (!inhibit_i && src_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_o <= 1'b0;
    else        upd_o <= fire;
  end

  assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !upd_o);

  assert_inhibit_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_i && mode_i != 3'd7) |=> !upd_o);

  assert_demand_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && mode_i == 3'd7 && data_wr_i) |=> upd_o);

  assert_timer_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !inhibit_i && mode_i == 3'd0 && tmr_i[0]) |=> upd_o);
endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel #(
  parameter int unsigned N_TMR       = 4,
  parameter int unsigned N_EXT       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] tmr_ovf,
  input  logic [N_EXT-1:0] ext_trig,
  input  logic [2:0]       mode,
  input  logic [SEL_W-1:0] ext_sel,
  input  logic             inhibit,
  input  logic             enable,
  input  logic             data_wr,
  output logic             upd_pulse
);
  logic [N_EXT-1:0] ext_sync;
  logic             ext_rise;
  logic             ext_fall;

  dtrig_sync #(.WIDTH(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_trig),
    .sync_o  (ext_sync)
  );

  dtrig_edge #(.N_EXT(N_EXT)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .synced_i (ext_sync),
    .sel_i    (ext_sel),
    .mode_i   (mode),
    .rise_o   (ext_rise),
    .fall_o   (ext_fall)
  );

  dtrig_qual #(.N_TMR(N_TMR)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_i     (tmr_ovf),
    .rise_i    (ext_rise),
    .fall_i    (ext_fall),
    .mode_i    (mode),
    .inhibit_i (inhibit),
    .enable_i  (enable),
    .data_wr_i (data_wr),
    .upd_o     (upd_pulse)
  );

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> !upd_pulse);
endmodule

// File: tb/test_dac_trig_sel.sv
module test_dac_trig_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tmr_ovf = '0;
  logic [7:0] ext_trig = '0;
  logic [2:0] mode = '0;
  logic [2:0] ext_sel = '0;
  logic       inhibit = 1'b0;
  logic       enable = 1'b0;
  logic       data_wr = 1'b0;
  logic       upd_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dac_trig_sel i_dac_trig_sel (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .ext_trig(ext_trig),
    .mode(mode), .ext_sel(ext_sel), .inhibit(inhibit), .enable(enable),
    .data_wr(data_wr), .upd_pulse(upd_pulse)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (mode=%0d sel=%0d inh=%0d en=%0d)",
               req, got, exp, mode, ext_sel, inhibit, enable);
    end
  endtask

  // Toggle one line, return pulse seen in 3rd cycle and total over 6 cycles.
  task automatic drive_line(input int l, input bit v, output int at3, output int cnt);
    ext_trig[l] = v;
    cnt = 0;
    at3 = 0;
    for (int c = 1; c <= 6; c++) begin
      cyc();
      if (upd_pulse) cnt++;
      if (c == 3) at3 = int'(upd_pulse);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int at3, cnt, exp;
    repeat (3) cyc();
    check("R1 during reset", int'(upd_pulse), 0);
    rst_n = 1'b1;
    cyc();
    check("R1 after reset", int'(upd_pulse), 0);

    // R2 R6 R8 R9: timer and on-demand sweep across all modes and gates.
    for (int m = 0; m < 8; m++)
      for (int ih = 0; ih < 2; ih++)
        for (int en = 0; en < 2; en++)
          for (int t = 0; t < 5; t++) begin
            mode = 3'(m); inhibit = ih[0]; enable = en[0];
            cyc(); cyc();
            if (t < 4) tmr_ovf = 4'(1 << t); else data_wr = 1'b1;
            exp = (en == 1 && ((t == 4 && m == 7) || (t < 4 && m == t && ih == 0))) ? 1 : 0;
            cyc();
            tmr_ovf = '0; data_wr = 1'b0;
            check(t == 4 ? "R6/R8/R9 data write" : "R2/R6/R8/R9 timer", int'(upd_pulse), exp);
            cyc();
            check("R11 pulse ends", int'(upd_pulse), 0);
          end

    // R3 R4 R5 R7 R8 R9 R11: edge sweep over sources and lines.
    for (int m = 4; m < 7; m++)
      for (int gate = 0; gate < 3; gate++)
        for (int s = 0; s < 8; s++)
          for (int l = 0; l < 8; l++) begin
            mode = 3'(m); ext_sel = 3'(s);
            inhibit = (gate == 1); enable = (gate != 2);
            repeat (2) cyc();
            exp = (gate == 0 && l == s && (m == 4 || m == 6)) ? 1 : 0;
            drive_line(l, 1'b1, at3, cnt);
            check("R3/R5/R7/R8/R9 rise latency", at3, exp);
            check("R11 rise count", cnt, exp);
            exp = (gate == 0 && l == s && (m == 5 || m == 6)) ? 1 : 0;
            drive_line(l, 1'b0, at3, cnt);
            check("R4/R5/R7 fall latency", at3, exp);
            check("R11 fall count", cnt, exp);
          end

    // R10: switching to a line already high gives no false edge.
    inhibit = 1'b0; enable = 1'b1; mode = 3'd4; ext_sel = 3'd0;
    ext_trig = 8'h08;
    repeat (5) cyc();
    ext_sel = 3'd3;
    cnt = 0;
    for (int c = 0; c < 6; c++) begin cyc(); if (upd_pulse) cnt++; end
    check("R10 reselect high line", cnt, 0);
    ext_trig = 8'h00; mode = 3'd6;
    repeat (5) cyc();

    // R10: mode switch while the selected line is high.
    mode = 3'd5; ext_sel = 3'd2; ext_trig = 8'h04;
    repeat (6) cyc();
    mode = 3'd6;
    cnt = 0;
    for (int c = 0; c < 6; c++) begin cyc(); if (upd_pulse) cnt++; end
    check("R10 mode change high line", cnt, 0);
    ext_trig = 8'h00;
    repeat (6) cyc();

    // R10 coincidence: select change lands with the synchronized edge.
    mode = 3'd4; ext_sel = 3'd0;
    repeat (4) cyc();
    ext_trig[1] = 1'b1;
    cyc(); cyc();
    ext_sel = 3'd1;
    cnt = 0;
    for (int c = 0; c < 6; c++) begin cyc(); if (upd_pulse) cnt++; end
    check("R10 reselect coincident edge dropped", cnt, 0);
    ext_trig[1] = 1'b0;
    repeat (4) cyc();
    drive_line(1, 1'b1, at3, cnt);
    check("R3 edge after settle", cnt, 1);
    drive_line(1, 1'b0, at3, cnt);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule